// File: doc/BRIEF.md
# Fused Multiply-Add NaN Result Selector

This block decides which NaN a single-precision fused multiply-add `(a*b)+c` returns once at least one operand is a NaN, or once the product is zero times infinity. Each of the three operands is classified as quiet NaN, signaling NaN or non-NaN. A two-bit policy input then picks one of four priority schemes. The block reports which operand it chose (or that a generated default NaN is used), gives the final 32-bit NaN with any signaling choice made quiet, and raises an invalid-operation flag.

The arithmetic datapath sits upstream and also supplies the zero-times-infinity indication. It presents the operands with `in_valid`. One clock later the block returns the registered decision with `out_valid`. A default-NaN mode bit replaces the result with the canonical quiet NaN after the choice has been made, so the selection code and the invalid flag are still reported in full.

Top module: `fma_nan_sel`

## Requirements
- R1: A decision is registered on the clock edge where `in_valid` is high and is presented with `out_valid` high one cycle later. `out_valid` is low in every other cycle. The selection code is 0 for a, 1 for b, 2 for c and 3 for the generated default NaN.
- R2: An operand is a NaN when bits 30:23 are all ones and bits 22:0 are not all zero. A NaN is quiet when bit 22 is set and signaling when bit 22 is clear. An infinity (fraction zero) is not a NaN. `invalid` is high whenever any operand is a signaling NaN.
- R3: Under policy 0, infzero together with a quiet-NaN c selects code 3 and raises `invalid`. This check takes precedence over every other rule.
- R4: Under policy 0, in every other case the first match in this list is chosen: c signaling, a signaling, b signaling, c quiet, a quiet. If none matches, b is chosen.
- R5: Under policy 1, infzero always selects code 3 and raises `invalid`.
- R6: Under policy 1 without infzero, the first match in this list is chosen: a signaling, b signaling, c signaling, a quiet, b quiet. If none matches, c is chosen.
- R7: Under policy 2, infzero raises `invalid` and selects c.
- R8: Under policy 2 without infzero, a is chosen if it is a NaN, otherwise c if it is a NaN, otherwise b.
- R9: Under policy 3, a is chosen if it is a NaN, otherwise b if it is a NaN, otherwise c. Infzero has no effect on the code or on `invalid`.
- R10: With default-NaN mode high, the result is 0x7FC00000. The selection code and `invalid` are the same as with the mode low.
- R11: A selected signaling operand is output with bit 22 set and all other bits unchanged. A selected quiet operand is output unchanged. Code 3 outputs 0x7FC00000.
- R12: With no NaN operand and infzero low, `invalid` is low. The code and the result are don't-care in this case.
- R13: During and directly after reset, `out_valid`, `invalid`, the selection code and the result are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier |
| op_c | input | 32 | Addend |
| infzero | input | 1 | Product is zero times infinity |
| policy | input | 2 | Priority scheme select (0..3) |
| dflt_mode | input | 1 | Force the canonical default NaN as result |
| out_valid | output | 1 | Registered decision is valid |
| sel_code | output | 2 | 0 a, 1 b, 2 c, 3 default NaN |
| result | output | 32 | Final NaN value |
| invalid | output | 1 | Invalid-operation flag |

## Verification
The hardest case to reach is the set of combinations where infzero meets operand kinds that a real multiply-add would not produce together. Examples are infzero with a signaling c under policy 0, which must fall through to the priority list instead of the default NaN, and infzero with a non-NaN c under policy 2. The stimulus sweeps every mix of non-NaN, quiet and signaling for the three operands against all four policies, both infzero levels and both default-NaN levels. It uses a distinct payload and sign per operand, so a wrong pick or a wrong quieting bit shows in the result. Directed items add the all-ones signaling payload, negative signaling NaNs and infinities that must not count as NaNs.

// File: rtl/fma_nan_sel_pkg.sv
package fma_nan_sel_pkg;

    typedef enum logic [1:0] {
        SEL_A   = 2'd0,
        SEL_B   = 2'd1,
        SEL_C   = 2'd2,
        SEL_DEF = 2'd3
    } sel_e;

    typedef enum logic [1:0] {
        POL_ADDEND_SIG_FIRST = 2'd0,
        POL_SIG_IN_ORDER     = 2'd1,
        POL_LEAD_THEN_ADDEND = 2'd2,
        POL_FIRST_NAN        = 2'd3
    } pol_e;

    typedef struct packed {
        logic is_nan;
        logic is_quiet;
        logic is_sig;
    } opclass_t;

    localparam int unsigned NUM_OPS = 3;

endpackage

// File: rtl/nan_classify.sv
module nan_classify
    import fma_nan_sel_pkg::*;
#(
    parameter int unsigned EXP_W  = 8,
    parameter int unsigned FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] val,
    output opclass_t              cls
);
    localparam int unsigned QBIT = FRAC_W - 1;

    logic exp_full;
    logic frac_nz;

    always_comb begin
        exp_full     = &val[FRAC_W +: EXP_W];
        frac_nz      = |val[FRAC_W-1:0];
        cls.is_nan   = exp_full && frac_nz;
        cls.is_quiet = exp_full && val[QBIT];
        cls.is_sig   = exp_full && !val[QBIT] && frac_nz;
    end
endmodule

// File: rtl/nan_policy_pick.sv
module nan_policy_pick
    import fma_nan_sel_pkg::*;
(
    input  opclass_t   cls_a,
    input  opclass_t   cls_b,
    input  opclass_t   cls_c,
    input  logic       infzero,
    input  logic [1:0] policy,
    output sel_e       sel,
    output logic       iz_invalid
);
    pol_e pol;

    always_comb begin
        pol        = pol_e'(policy);
        sel        = SEL_B;
        iz_invalid = 1'b0;
        unique case (pol)
            POL_ADDEND_SIG_FIRST: begin
                if (infzero && cls_c.is_quiet) begin
                    sel        = SEL_DEF;
                    iz_invalid = 1'b1;
                end else if (cls_c.is_sig)   sel = SEL_C;
                else if (cls_a.is_sig)       sel = SEL_A;
                else if (cls_b.is_sig)       sel = SEL_B;
                else if (cls_c.is_quiet)     sel = SEL_C;
                else if (cls_a.is_quiet)     sel = SEL_A;
                else                         sel = SEL_B;
            end
            POL_SIG_IN_ORDER: begin
                if (infzero) begin
                    sel        = SEL_DEF;
                    iz_invalid = 1'b1;
                end else if (cls_a.is_sig)   sel = SEL_A;
                else if (cls_b.is_sig)       sel = SEL_B;
                else if (cls_c.is_sig)       sel = SEL_C;
                else if (cls_a.is_quiet)     sel = SEL_A;
                else if (cls_b.is_quiet)     sel = SEL_B;
                else                         sel = SEL_C;
            end
            POL_LEAD_THEN_ADDEND: begin
                if (infzero) begin
                    sel        = SEL_C;
                    iz_invalid = 1'b1;
                end else if (cls_a.is_nan)   sel = SEL_A;
                else if (cls_c.is_nan)       sel = SEL_C;
                else                         sel = SEL_B;
            end
            default: begin
                if (cls_a.is_nan)            sel = SEL_A;
                else if (cls_b.is_nan)       sel = SEL_B;
                else                         sel = SEL_C;
            end
        endcase
    end
endmodule

// File: rtl/nan_result_form.sv
module nan_result_form
    import fma_nan_sel_pkg::*;
#(
    parameter int unsigned        DATA_W      = 32,
    parameter int unsigned        QBIT        = 22,
    parameter logic [DATA_W-1:0]  DEFAULT_NAN = 32'h7FC0_0000
) (
    input  logic [DATA_W-1:0]  op_a,
    input  logic [DATA_W-1:0]  op_b,
    input  logic [DATA_W-1:0]  op_c,
    input  logic [NUM_OPS-1:0] sig_vec,
    input  sel_e               sel,
    input  logic               dflt_mode,
    output logic [DATA_W-1:0]  result
);
    logic [DATA_W-1:0] picked;
    logic              quiet_it;

    always_comb begin
        picked   = DEFAULT_NAN;
        quiet_it = 1'b0;
        unique case (sel)
            SEL_A: begin picked = op_a; quiet_it = sig_vec[0]; end
            SEL_B: begin picked = op_b; quiet_it = sig_vec[1]; end
            SEL_C: begin picked = op_c; quiet_it = sig_vec[2]; end
            default: begin picked = DEFAULT_NAN; quiet_it = 1'b0; end
        endcase
        if (quiet_it) begin
            picked[QBIT] = 1'b1;
        end
        result = dflt_mode ? DEFAULT_NAN : picked;
    end
endmodule

// File: rtl/fma_nan_sel.sv
module fma_nan_sel
    import fma_nan_sel_pkg::*;
#(
    parameter int unsigned EXP_W  = 8,
    parameter int unsigned FRAC_W = 23
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [EXP_W+FRAC_W:0]   op_a,
    input  logic [EXP_W+FRAC_W:0]   op_b,
    input  logic [EXP_W+FRAC_W:0]   op_c,
    input  logic                    infzero,
    input  logic [1:0]              policy,
    input  logic                    dflt_mode,
    output logic                    out_valid,
    output logic [1:0]              sel_code,
    output logic [EXP_W+FRAC_W:0]   result,
    output logic                    invalid
);
    localparam int unsigned       DATA_W      = EXP_W + FRAC_W + 1;
    localparam int unsigned       QBIT        = FRAC_W - 1;
    localparam logic [DATA_W-1:0] DEFAULT_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef struct packed {
        logic              valid;
        sel_e              sel;
        logic [DATA_W-1:0] res;
        logic              inv;
    } state_t;

    state_t st_d, st_q;

    logic [DATA_W-1:0]  ops [NUM_OPS];
    opclass_t           cls [NUM_OPS];
    logic [NUM_OPS-1:0] sig_vec;
    sel_e               pick_sel;
    logic               iz_invalid;
    logic [DATA_W-1:0]  formed;

    assign ops[0] = op_a;
    assign ops[1] = op_b;
    assign ops[2] = op_c;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_cls
        nan_classify #(
            .EXP_W  (EXP_W),
            .FRAC_W (FRAC_W)
        ) u_cls (
            .val (ops[g]),
            .cls (cls[g])
        );
        assign sig_vec[g] = cls[g].is_sig;
    end

    nan_policy_pick u_pick (
        .cls_a      (cls[0]),
        .cls_b      (cls[1]),
        .cls_c      (cls[2]),
        .infzero    (infzero),
        .policy     (policy),
        .sel        (pick_sel),
        .iz_invalid (iz_invalid)
    );

    nan_result_form #(
        .DATA_W      (DATA_W),
        .QBIT        (QBIT),
        .DEFAULT_NAN (DEFAULT_NAN)
    ) u_form (
        .op_a      (op_a),
        .op_b      (op_b),
        .op_c      (op_c),
        .sig_vec   (sig_vec),
        .sel       (pick_sel),
        .dflt_mode (dflt_mode),
        .result    (formed)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.sel = pick_sel;
            st_d.res = formed;
            st_d.inv = (|sig_vec) | iz_invalid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign sel_code  = st_q.sel;
    assign result    = st_q.res;
    assign invalid   = st_q.inv;
endmodule

// File: rtl/fma_nan_sel_chk.sv
module fma_nan_sel_chk #(
    parameter int unsigned EXP_W  = 8,
    parameter int unsigned FRAC_W = 23
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [EXP_W+FRAC_W:0] op_a,
    input logic [EXP_W+FRAC_W:0] op_b,
    input logic [EXP_W+FRAC_W:0] op_c,
    input logic                  infzero,
    input logic [1:0]            policy,
    input logic                  dflt_mode,
    input logic                  out_valid,
    input logic [1:0]            sel_code,
    input logic [EXP_W+FRAC_W:0] result,
    input logic                  invalid
);
    localparam int unsigned QBIT = FRAC_W - 1;
    localparam logic [EXP_W+FRAC_W:0] DEF_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic [2:0] is_nan_v;
    logic [2:0] is_sig_v;

    always_comb begin
        is_nan_v[0] = (op_a[FRAC_W +: EXP_W] == {EXP_W{1'b1}}) && (op_a[FRAC_W-1:0] != '0);
        is_nan_v[1] = (op_b[FRAC_W +: EXP_W] == {EXP_W{1'b1}}) && (op_b[FRAC_W-1:0] != '0);
        is_nan_v[2] = (op_c[FRAC_W +: EXP_W] == {EXP_W{1'b1}}) && (op_c[FRAC_W-1:0] != '0);
        is_sig_v[0] = is_nan_v[0] && !op_a[QBIT];
        is_sig_v[1] = is_nan_v[1] && !op_b[QBIT];
        is_sig_v[2] = is_nan_v[2] && !op_c[QBIT];
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid) else $error("valid lost"); // R1

    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid) else $error("spurious valid"); // R1

    AST_SNAN_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (|is_sig_v)) |=> invalid) else $error("snan not flagged"); // R2

    AST_P1_IZ_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && policy == 2'd1 && infzero) |=> (sel_code == 2'd3 && invalid))
        else $error("policy1 infzero"); // R5

    AST_P2_IZ_ADDEND: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && policy == 2'd2 && infzero) |=> (sel_code == 2'd2 && invalid))
        else $error("policy2 infzero"); // R7

    AST_P3_IZ_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && policy == 2'd3 && !(|is_sig_v)) |=> !invalid)
        else $error("policy3 invalid"); // R9

    AST_DFLT_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dflt_mode) |=> (result == DEF_NAN))
        else $error("default override"); // R10

    AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !infzero && (|is_nan_v)) |=>
            (result[QBIT] && result[FRAC_W +: EXP_W] == {EXP_W{1'b1}}))
        else $error("result not quiet"); // R11
endmodule

bind fma_nan_sel fma_nan_sel_chk #(
    .EXP_W  (EXP_W),
    .FRAC_W (FRAC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .op_c      (op_c),
    .infzero   (infzero),
    .policy    (policy),
    .dflt_mode (dflt_mode),
    .out_valid (out_valid),
    .sel_code  (sel_code),
    .result    (result),
    .invalid   (invalid)
);

// File: tb/fma_nan_sel_tb.sv
module fma_nan_sel_tb;
    localparam logic [31:0] DEF_NAN = 32'h7FC0_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0, op_b = '0, op_c = '0;
    logic        infzero = 1'b0;
    logic [1:0]  policy = '0;
    logic        dflt_mode = 1'b0;
    logic        out_valid;
    logic [1:0]  sel_code;
    logic [31:0] result;
    logic        invalid;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [1:0]  sel;
        logic [31:0] res;
        logic        inv;
        bit          care;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #4 clk = ~clk;

    fma_nan_sel u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .op_c      (op_c),
        .infzero   (infzero),
        .policy    (policy),
        .dflt_mode (dflt_mode),
        .out_valid (out_valid),
        .sel_code  (sel_code),
        .result    (result),
        .invalid   (invalid)
    );

    function automatic bit f_nan(input logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 23'd0);
    endfunction
    function automatic bit f_q(input logic [31:0] x);
        return f_nan(x) && x[22];
    endfunction
    function automatic bit f_s(input logic [31:0] x);
        return f_nan(x) && !x[22];
    endfunction

    function automatic exp_t model(input logic [31:0] a, input logic [31:0] b,
                                   input logic [31:0] c, input bit iz,
                                   input logic [1:0] pol, input bit dm);
        exp_t e;
        bit iz_inv = 1'b0;
        logic [31:0] pick;
        e.care = 1'b1;
        case (pol)
            2'd0: begin
                e.tag = "R4";
                if (iz && f_q(c)) begin e.sel = 3; iz_inv = 1; e.tag = "R3"; end
                else if (f_s(c)) e.sel = 2;
                else if (f_s(a)) e.sel = 0;
                else if (f_s(b)) e.sel = 1;
                else if (f_q(c)) e.sel = 2;
                else if (f_q(a)) e.sel = 0;
                else e.sel = 1;
            end
            2'd1: begin
                e.tag = "R6";
                if (iz) begin e.sel = 3; iz_inv = 1; e.tag = "R5"; end
                else if (f_s(a)) e.sel = 0;
                else if (f_s(b)) e.sel = 1;
                else if (f_s(c)) e.sel = 2;
                else if (f_q(a)) e.sel = 0;
                else if (f_q(b)) e.sel = 1;
                else e.sel = 2;
            end
            2'd2: begin
                e.tag = "R8";
                if (iz) begin e.sel = 2; iz_inv = 1; e.tag = "R7"; end
                else if (f_nan(a)) e.sel = 0;
                else if (f_nan(c)) e.sel = 2;
                else e.sel = 1;
            end
            default: begin
                e.tag = "R9";
                if (f_nan(a)) e.sel = 0;
                else if (f_nan(b)) e.sel = 1;
                else e.sel = 2;
            end
        endcase
        e.inv = f_s(a) || f_s(b) || f_s(c) || iz_inv;
        case (e.sel)
            2'd0: pick = a;
            2'd1: pick = b;
            2'd2: pick = c;
            default: pick = DEF_NAN;
        endcase
        // R11: signaling choice gains bit 22
        if (e.sel != 2'd3 && f_s(pick)) pick[22] = 1'b1;
        e.res = dm ? DEF_NAN : pick;
        if (dm) e.tag = {e.tag, "/R10"};
        else if (e.sel != 2'd3 && f_nan(pick)) e.tag = {e.tag, "/R11"};
        if (!f_nan(a) && !f_nan(b) && !f_nan(c) && !iz) begin
            e.care = 1'b0;
            e.tag  = "R12";
        end
        return e;
    endfunction

    task automatic drive(input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] c, input bit iz,
                         input logic [1:0] pol, input bit dm);
        @(negedge clk);
        op_a      = a;
        op_b      = b;
        op_c      = c;
        infzero   = iz;
        policy    = pol;
        dflt_mode = dm;
        in_valid  = 1'b1;
        exp_q.push_back(model(a, b, c, iz, pol, dm));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: one registered result per pushed item, R1
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                n_checks++;
                n_fail++;
                $display("FAIL R1 unexpected out_valid: actual 1 expected 0");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (invalid !== e.inv ||
                    (e.care && (sel_code !== e.sel || result !== e.res))) begin
                    n_fail++;
                    $display("FAIL %s actual sel=%0d res=%h inv=%b expected sel=%0d res=%h inv=%b",
                             e.tag, sel_code, result, invalid, e.sel, e.res, e.inv);
                end
            end
        end
    end

    function automatic logic [31:0] val_of(input int kind, input int slot);
        logic [31:0] v;
        case (kind)
            0: v = (slot == 0) ? 32'h7F80_0000 : 32'h3F80_0000 + slot;
            1: v = 32'h7FC0_0010 | (32'(slot) << 4) | (slot == 1 ? 32'h8000_0000 : 0);
            default: v = 32'h7F80_0100 | (32'(slot) << 12) | (slot == 2 ? 32'h8000_0000 : 0);
        endcase
        return v;
    endfunction

    initial begin : main
        // R13 reset state
        repeat (3) @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || invalid !== 1'b0 || sel_code !== 2'd0 || result !== 32'd0) begin
            n_fail++;
            $display("FAIL R13 reset: actual v=%b inv=%b sel=%0d res=%h expected all zero",
                     out_valid, invalid, sel_code, result);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || invalid !== 1'b0) begin
            n_fail++;
            $display("FAIL R13 after reset: actual v=%b inv=%b expected 0 0", out_valid, invalid);
        end

        // R2 boundary: all-ones signaling payload, negative signaling, infinities
        drive(32'h7FBF_FFFF, 32'h3F80_0000, 32'h4000_0000, 1'b0, 2'd3, 1'b0);
        drive(32'h7F80_0000, 32'hFF80_0001, 32'h4000_0000, 1'b0, 2'd3, 1'b0);
        drive(32'h7F80_0000, 32'hFF80_0000, 32'h0000_0000, 1'b0, 2'd0, 1'b0);
        drive(32'h3F80_0000, 32'h4000_0000, 32'h7FC0_0000, 1'b1, 2'd3, 1'b0);
        idle(3);

        // Full sweep: operand kinds x policy x infzero x default mode
        for (int pol = 0; pol < 4; pol++)
            for (int iz = 0; iz < 2; iz++)
                for (int dm = 0; dm < 2; dm++)
                    for (int ka = 0; ka < 3; ka++)
                        for (int kb = 0; kb < 3; kb++)
                            for (int kc = 0; kc < 3; kc++)
                                drive(val_of(ka, 0), val_of(kb, 1), val_of(kc, 2),
                                      iz[0], pol[1:0], dm[0]);
        idle(2);

        // R1 gaps: a lone item then idle
        drive(32'h7FC0_0001, 32'h7FC0_0002, 32'h7FC0_0003, 1'b0, 2'd1, 1'b0);
        idle(4);

        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R1 missing results: actual %0d pending expected 0", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        done = 1'b1;
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule